// File: doc/BRIEF.md
# Prioritised Sticky Error Latch

This block sits behind the frame decoder of a digital audio receiver. Each master-clock cycle it takes a vector of error flags, one per detected fault, and ranks them by severity into a 3-bit code. The latch keeps the most severe code it has seen since it was last cleared. A new fault replaces the stored code only when the new fault ranks higher.

Three output pins are shared between the latched code and three status bits that come from elsewhere. When the select input is low the pins carry the latched code. When select is high they carry the status bits. The same select line also clears the latch: if select stays high for more than a fixed number of consecutive cycles (8 by default), the latch returns to "no error". A fault that arrives in the cycle the clear happens is not lost.

Top module: `err_latch_top`

## Requirements
- R1: After synchronous reset, `code_o` and `pins_o` are both 000.
- R2: The flag vector maps to codes by bit position: bit0 validity=001, bit1 slipped sample=010, bit2 CRC=011, bit3 parity=100, bit4 biphase=101, bit5 loss of lock=110. When several flags are set, the highest set bit wins, and the latch takes that code at the clock edge where the flags are sampled.
- R3: A flag that ranks at or below the stored code leaves `code_o` unchanged.
- R4: A flag that ranks above the stored code replaces it at the sampling edge.
- R5: While `sel_i` is low, `pins_o` shows the value `code_o` had one cycle earlier.
- R6: While `sel_i` is high, `pins_o` shows the value `stat_i` had one cycle earlier.
- R7: When `sel_i` is sampled high on 9 consecutive edges, the latch is cleared to 000 at the 9th edge.
- R8: If `sel_i` is high for 8 edges or fewer, the latch is not cleared. The high-time count restarts whenever `sel_i` is sampled low.
- R9: A flag present at the clearing edge is kept, so the latch takes that flag's code instead of 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| sel_i | input | 1 | pin select (low = error code shown); a long high pulse clears the latch |
| err_i | input | 6 | per-cycle error flags, bit order as in R2 |
| stat_i | input | 3 | status bits shown on the pins when select is high |
| pins_o | output | 3 | registered shared output pins |
| code_o | output | 3 | latched error code |

## Verification
The assertions check on every cycle that the code never falls except at a clear, that a higher-ranked flag is taken at once, that a clearing edge loads the incoming code, and that the pins follow the code one cycle later while select is low. Some behaviour only the bench scenarios can show. These are the exact priority mapping for all 64 flag vectors and all pairs of vectors, the boundary between an 8-cycle and a 9-cycle select pulse, the restart of the count after a low gap, and the keeping of a fault that arrives at the clearing edge.

// File: rtl/err_latch_pkg.sv
package err_latch_pkg;
  localparam int unsigned N_FLAGS = 6;
  localparam int unsigned CODE_W  = $clog2(N_FLAGS + 1);
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_NONE = '0;
endpackage

// File: rtl/err_prio_enc.sv
module err_prio_enc
  import err_latch_pkg::*;
#(
  parameter int unsigned NF = N_FLAGS
) (
  input  logic [NF-1:0] flags_i,
  output code_t         code_o
);
  always_comb begin
    code_o = CODE_NONE;
    for (int i = 0; i < NF; i++) begin
      if (flags_i[i]) code_o = code_t'(i + 1);
    end
  end

  // R2: no flag set means no error
  always_comb begin
    if (flags_i == '0) a_r2_none_code : assert (code_o == CODE_NONE);
  end
endmodule

// File: rtl/err_clr_timer.sv
module err_clr_timer #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  output logic clr_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)             hi_cnt <= '0;
    else if (!sel_i)     hi_cnt <= '0;
    else if (hi_cnt != LIMIT) hi_cnt <= hi_cnt + 1'b1;
  end

  assign clr_o = sel_i && (hi_cnt == LIMIT);

  // R8: a select that has just risen cannot clear
  a_r8_no_early_clear : assert property (@(posedge clk) disable iff (rst)
    (!$past(sel_i) && !$past(rst)) |-> !clr_o);
endmodule

// File: rtl/err_sticky_reg.sv
module err_sticky_reg
  import err_latch_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr_i,
  input  code_t new_i,
  output code_t code_o
);
  always_ff @(posedge clk) begin
    if (rst)                 code_o <= CODE_NONE;
    else if (clr_i)          code_o <= new_i;
    else if (new_i > code_o) code_o <= new_i;
  end

  a_r3_never_drops : assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_i) && !$past(rst)) |-> code_o >= $past(code_o));
  a_r4_higher_taken : assert property (@(posedge clk) disable iff (rst)
    (!clr_i && new_i > code_o) |=> code_o == $past(new_i));
  a_r9_clear_keeps_new : assert property (@(posedge clk) disable iff (rst)
    clr_i |=> code_o == $past(new_i));
endmodule

// File: rtl/err_latch_top.sv
module err_latch_top
  import err_latch_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic [N_FLAGS-1:0] err_i,
  input  logic [CODE_W-1:0] stat_i,
  output logic [CODE_W-1:0] pins_o,
  output logic [CODE_W-1:0] code_o
);
  code_t enc_code;
  code_t held_code;
  logic  clr;

  err_prio_enc #(.NF(N_FLAGS)) u_enc (
    .flags_i (err_i),
    .code_o  (enc_code)
  );

  err_clr_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .sel_i (sel_i),
    .clr_o (clr)
  );

  err_sticky_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .new_i  (enc_code),
    .code_o (held_code)
  );

  always_ff @(posedge clk) begin
    if (rst) pins_o <= '0;
    else     pins_o <= sel_i ? stat_i : held_code;
  end

  assign code_o = held_code;

  a_r5_pins_show_code : assert property (@(posedge clk) disable iff (rst)
    (!$past(sel_i) && !$past(rst)) |-> pins_o == $past(held_code));
  a_r6_pins_show_stat : assert property (@(posedge clk) disable iff (rst)
    ($past(sel_i) && !$past(rst)) |-> pins_o == $past(stat_i));
endmodule

// File: tb/sim_err_latch_top.sv
`timescale 1ns/1ps
module sim_err_latch_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       sel;
  logic [5:0] err;
  logic [2:0] stat;
  logic [2:0] pins;
  logic [2:0] code;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  err_latch_top u0 (
    .clk(clk), .rst(rst), .sel_i(sel), .err_i(err),
    .stat_i(stat), .pins_o(pins), .code_o(code)
  );

  function automatic int rank(input logic [5:0] v);
    int r = 0;
    for (int i = 0; i < 6; i++) if (v[i]) r = i + 1;
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold_sel(input int n);
    sel = 1'b1;
    for (int i = 0; i < n; i++) tick();
    sel = 1'b0;
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; sel = 1'b0; err = '0; stat = '0;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    chk("R1 code", code, 0);
    chk("R1 pins", pins, 0);

    // R2/R3/R4: every ordered pair of flag vectors
    for (int v = 0; v < 64; v++) begin
      for (int w = 0; w < 64; w++) begin
        hold_sel(9);
        if (v == 0 && w == 0) chk("R7 cleared", code, 0);
        err = 6'(v); tick();
        if (w == 0) chk("R2 single", code, rank(6'(v)));
        err = 6'(w); tick();
        err = '0;
        chk(rank(6'(w)) > rank(6'(v)) ? "R4 pair" : "R3 pair",
            code, rank(6'(w)) > rank(6'(v)) ? rank(6'(w)) : rank(6'(v)));
      end
    end

    // R5: pins follow code with sel low
    hold_sel(9);
    err = 6'b001000; tick(); err = '0;
    tick();
    chk("R5 pins code", pins, 4);

    // R6: pins show stat with sel high (short pulses, no clear)
    for (int s = 0; s < 8; s++) begin
      sel = 1'b1; stat = 3'(s); tick();
      chk("R6 pins stat", pins, s);
      sel = 1'b0; tick();
    end
    chk("R6 no clear", code, 4);

    // R8: 8-cycle pulse does not clear
    hold_sel(8); tick();
    chk("R8 eight high", code, 4);
    // R8: restart after low gap
    hold_sel(5); tick(); hold_sel(5); tick();
    chk("R8 restart", code, 4);
    // R7: 9-cycle pulse clears
    hold_sel(9);
    chk("R7 nine high", code, 0);
    tick();
    chk("R7 pins", pins, 0);

    // R9: flag at the clearing edge is kept
    err = 6'b100000; tick(); err = '0;
    chk("R9 setup", code, 6);
    sel = 1'b1;
    for (int i = 0; i < 8; i++) tick();
    err = 6'b000100; tick();
    err = '0; sel = 1'b0;
    chk("R9 kept", code, 3);
    tick();
    chk("R9 after", code, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule